// File: doc/BRIEF.md
# Histogram bin accumulator

This block builds an event histogram for a multichannel analyser. Each sample
presented on a valid/ready input is a two's-complement code; the block turns it
into a linear bin address and adds one to the 16-bit count held in that bin of
an internal synchronous RAM. The update is a three-step pipelined
read-modify-write. The block holds off new samples through its ready output
whenever an update cannot be accepted safely. A count that has reached full
scale stays there.

A one-cycle clear command zeroes every bin. The same walk runs by itself after
reset, so the histogram always starts empty. While no accumulation or clear is
under way, a host can read any bin through a simple read port. The data comes
back one cycle after the address.

Top module: `mca_hist_acc`

## Requirements
- R1: The bin address is the upper ADDR_W bits of the sample with the sign bit inverted. For the 16-bit sample and ADDR_W=6: 0x8000 maps to bin 0, 0xE000 to bin 24, 0x0000 to bin 32 and 0x7FFF to bin 63.
- R2: Each sample taken on a clock edge with smp_valid and smp_ready both high adds exactly one to its own bin and changes no other bin.
- R3: A bin that already holds all ones keeps all ones when hit again and never wraps to zero.
- R4: smp_ready is high only in the idle state or in the write cycle of an update, and only when no clear is pending. An update takes three cycles: read issue, data register, write. A steady stream of samples is accepted one every two cycles.
- R5: In the cycle after a sample is accepted, smp_ready is low. A sample held valid during back-pressure is taken later and is not lost.
- R6: A sample accepted in the write cycle of an update to the same bin is counted on top of the value being written, so back-to-back hits on one bin all count.
- R7: A one-cycle pulse on clr_req lets any update already in flight finish. The block then writes zero to all 2^ADDR_W bins, one per cycle, with smp_ready low until the walk is done. Reset starts the same walk, so smp_ready first rises 2^ADDR_W cycles after reset is released.
- R8: A read request (rd_en with rd_addr) is accepted only when the block is idle, no clear is pending and smp_valid is low. rd_valid then goes high for the next cycle with the bin's count on rd_data. A request made at any other time leaves rd_valid low and changes no bin.
- R9: While reset is asserted, smp_ready and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present |
| smp_data | input | SAMPLE_W | Two's-complement sample code |
| smp_ready | output | 1 | Block can take a sample this cycle |
| clr_req | input | 1 | Pulse: zero every bin |
| rd_en | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Bin to read |
| rd_valid | output | 1 | rd_data holds the requested count |
| rd_data | output | CNT_W | Count of the requested bin |

## Verification
The bench drives back-to-back hits on a single bin. A design without the forwarding path would lose every second count there, because the RAM still returns the old value. It drives one bin far past full scale, where a design without saturation would wrap to a small count. It sends a clear while an update is in flight, where a design that ignored the pending clear would accept samples during the walk or leave a stale count behind. It also issues a host read in the same cycle as a sample; a design without the right priority would either raise rd_valid or drop the sample.

// File: rtl/mca_pkg.sv
package mca_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DAT  = 2'd1,
    ST_WR   = 2'd2,
    ST_CLR  = 2'd3
  } mca_state_e;

endpackage

// File: rtl/mca_bin_map.sv
module mca_bin_map #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 6
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [ADDR_W-1:0]   bin
);
  localparam int SHIFT = SAMPLE_W - ADDR_W;
  localparam logic [SAMPLE_W-1:0] SIGN_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // offset-binary conversion: flipping the sign bit makes the most negative code bin 0
  always_comb begin
    bin = ADDR_W'((sample ^ SIGN_MASK) >> SHIFT);
  end
endmodule

// File: rtl/mca_sat_inc.sv
module mca_sat_inc #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_comb begin
    if (&din) dout = din;
    else      dout = din + 1'b1;
  end
endmodule

// File: rtl/mca_bin_ram.sv
module mca_bin_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, read returns the old word on an address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mca_hist_acc.sv
module mca_hist_acc
  import mca_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 6,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_ready,
  input  logic                clr_req,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_valid,
  output logic [CNT_W-1:0]    rd_data
);
  localparam logic [ADDR_W-1:0] LAST_BIN = '1;

  mca_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  data_q;
  logic              fwd_hit;
  logic [CNT_W-1:0]  fwd_val;
  logic [ADDR_W-1:0] clr_addr;
  logic              clr_pend;

  logic [ADDR_W-1:0] smp_bin;
  logic [CNT_W-1:0]  inc_val;
  logic              accept;
  logic              rd_ok;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [CNT_W-1:0]  ram_wdata;
  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [CNT_W-1:0]  ram_rdata;

  mca_bin_map #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) i_map (
    .sample (smp_data),
    .bin    (smp_bin)
  );

  mca_sat_inc #(.W(CNT_W)) i_inc (
    .din  (data_q),
    .dout (inc_val)
  );

  mca_bin_ram #(.AW(ADDR_W), .DW(CNT_W)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  // handshake and port arbitration
  always_comb begin
    smp_ready = ((state == ST_IDLE) || (state == ST_WR)) && !clr_pend;
    accept    = smp_valid && smp_ready;
    rd_ok     = rd_en && (state == ST_IDLE) && !clr_pend && !smp_valid;
    ram_re    = accept || rd_ok;
    ram_raddr = accept ? smp_bin : rd_addr;
    ram_we    = (state == ST_WR) || (state == ST_CLR);
    ram_waddr = (state == ST_CLR) ? clr_addr : addr_q;
    ram_wdata = (state == ST_CLR) ? '0 : inc_val;
  end

  assign rd_data = ram_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CLR;
      clr_addr <= '0;
      clr_pend <= 1'b0;
      rd_valid <= 1'b0;
      fwd_hit  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      fwd_val  <= '0;
    end else begin
      rd_valid <= rd_ok;
      clr_pend <= clr_req || (clr_pend && (state != ST_IDLE));
      if (accept) begin
        addr_q  <= smp_bin;
        // same bin as the word being written now: the RAM will return the old count
        fwd_hit <= (state == ST_WR) && (smp_bin == addr_q);
        fwd_val <= inc_val;
      end
      unique case (state)
        ST_IDLE: begin
          if (clr_pend) begin
            state    <= ST_CLR;
            clr_addr <= '0;
          end else if (accept) begin
            state <= ST_DAT;
          end
        end
        ST_DAT: begin
          data_q <= fwd_hit ? fwd_val : ram_rdata;
          state  <= ST_WR;
        end
        ST_WR: begin
          state <= accept ? ST_DAT : ST_IDLE;
        end
        ST_CLR: begin
          clr_addr <= clr_addr + 1'b1;
          if (clr_addr == LAST_BIN) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: one cycle of back-pressure after every accepted sample
  p_bp_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> !smp_ready);

  // R3: an update write never wraps a count to zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) |-> (ram_wdata != '0));

  // R7: a clear request blocks samples from the next cycle on
  p_clr_backpressure_r7: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !smp_ready);

  // R8: read data is only flagged for a request made without a competing sample
  p_rd_valid_src_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(rd_en) && !$past(smp_valid)));

  // R7: during the clear walk the write port only ever writes zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLR) |-> (ram_we && ram_wdata == '0));
endmodule

// File: tb/test_mca_hist_acc.sv
module test_mca_hist_acc;
  localparam int SW = 16;
  localparam int AW = 6;
  localparam int CW = 8;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic          smp_ready;
  logic          clr_req = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [CW-1:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [CW-1:0] model [NB];

  always #2 clk = ~clk;

  mca_hist_acc #(.SAMPLE_W(SW), .ADDR_W(AW), .CNT_W(CW)) i_mca_hist_acc (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .clr_req(clr_req), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic int bin_of(input logic [SW-1:0] s);
    logic [SW-1:0] u;
    u = s + 16'h8000;
    return int'(u) / (1 << (SW - AW));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic bump(input int b);
    if (model[b] != '1) model[b] = model[b] + 1'b1;
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [SW-1:0] s);
    int n;
    n = 0;
    smp_data  = s;
    smp_valid = 1'b1;
    while (!smp_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    bump(bin_of(s));
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input string req);
    rd_en   = 1'b1;
    rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b1, req, int'(rd_valid), 1);
    chk(rd_data === model[a], req, int'(rd_data), int'(model[a]));
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!smp_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NB; i++) model[i] = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    void'($urandom(32'h5eed));
    clear_model();

    // R9 reset state
    repeat (4) @(negedge clk);
    chk(smp_ready === 1'b0, "R9", int'(smp_ready), 0);
    chk(rd_valid === 1'b0, "R9", int'(rd_valid), 0);
    rst = 1'b0;

    // R7 reset-triggered walk lasts one cycle per bin
    wait_ready(n);
    chk(n == NB, "R7", n, NB);
    for (int i = 0; i < NB; i++) rd_chk(i, "R7");

    // R1 / R2 mapping of corner codes
    send(16'h8000); drain();
    send(16'h0000); drain();
    send(16'h7FFF); drain();
    send(16'hE000); drain();
    rd_chk(0, "R1");
    rd_chk(32, "R1");
    rd_chk(63, "R1");
    rd_chk(24, "R1");
    rd_chk(1, "R2");

    // R4 / R5 back-pressure timing and R6 same-bin back-to-back
    send(16'h1234);
    chk(smp_ready === 1'b0, "R5", int'(smp_ready), 0);
    @(negedge clk);
    chk(smp_ready === 1'b1, "R4", int'(smp_ready), 1);
    send(16'h1234);
    send(16'h1234);
    send(16'h1300);
    send(16'h1234);
    drain();
    rd_chk(bin_of(16'h1234), "R6");

    // R3 saturation
    for (int i = 0; i < 300; i++) send(16'h7FFF);
    drain();
    rd_chk(63, "R3");
    chk(model[63] == 8'hFF, "R3", int'(model[63]), 255);

    // R8 read competing with a sample is refused, sample still counted
    smp_data  = 16'h0400;
    smp_valid = 1'b1;
    rd_en     = 1'b1;
    rd_addr   = 6'd0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R8", int'(rd_valid), 0);
    smp_valid = 1'b0;
    rd_en     = 1'b0;
    bump(bin_of(16'h0400));
    drain();
    rd_chk(bin_of(16'h0400), "R8");

    // R7 clear arriving while an update is in flight
    send(16'h2000);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    chk(smp_ready === 1'b0, "R7", int'(smp_ready), 0);
    rd_en   = 1'b1;
    rd_addr = 6'd5;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R8", int'(rd_valid), 0);
    wait_ready(n);
    clear_model();
    for (int i = 0; i < NB; i++) rd_chk(i, "R7");

    // constrained random stream with a hot bin (R2, R3, R6)
    for (int i = 0; i < 600; i++) begin
      logic [SW-1:0] s;
      if ($urandom_range(0, 1) == 0) s = 16'hC123;
      else                           s = SW'($urandom);
      send(s);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    drain();
    for (int i = 0; i < NB; i++) rd_chk(i, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule